// File: doc/BRIEF.md
# USB Interrupt Pending and Clear Logic

This block turns the event pulses of a USB serial interface engine into two CPU interrupt request lines. One line covers the engine's own events: general bus events, transmit-endpoint events and receive-endpoint events. The other line covers the arrival of start-of-frame packets. Each line has a pending flag and an enable bit. The request line is high when both the flag and the enable are set.

Both flags and both enables are visible in a single 32-bit control register. The same register also stores the PHY-side control bits and drives them out. The two flags are cleared in different ways. The engine flag clears as a side effect of any read of the register. The frame flag ignores reads and clears only when software writes a one to a dedicated command bit.

Each flag is held by a two-state machine. It stays in `PEND_IDLE` until an event arrives. The event moves it to `PEND_ACTIVE` (transition SET). The machine returns to `PEND_IDLE` only on a clear request with no event in the same cycle (transition CLEAR). In every other case it stays where it is (transition HOLD).

Top module: `usbirq_ctl`

## Requirements
- R1: After reset the control register reads 0x0000_0810, so bit 11 = 1 and bit 4 = 1 and every other bit is 0. Both interrupt lines are low, `role_device` = 1, `core_rst_n` = 0 and `phy_en` = 0.
- R2: A pulse on any bit of `gen_evt`, `tx_evt` or `rx_evt` sets the engine pending flag. The flag reads at bit 14 from the cycle after the pulse.
- R3: A cycle with `reg_rd` high clears the engine pending flag from the next cycle. The read itself still returns the flag value from before the clear.
- R4: A pulse on `sof_evt` sets the frame pending flag. The flag reads at bit 13 from the cycle after the pulse.
- R5: The frame pending flag clears only on a write with bit 12 = 1. Reads leave it unchanged, and bit 12 always reads 0.
- R6: A write never changes the engine pending flag. Writing 1 to bit 14 or bit 13 does not set either pending flag.
- R7: `irq_eng` equals bit 14 AND bit 11, and `irq_sof` equals bit 13 AND bit 10. A flag still latches while its enable is 0, and the line rises as soon as the enable is written to 1.
- R8: When an event and a clear for the same flag fall in the same cycle, the flag ends up set.
- R9: Bits 18 and 11:0 except bit 12 are read/write and read back as written. Bits 31:19 and 17:15 read 0. `role_device`, `core_rst_n` and `phy_en` follow bits 4, 2 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_evt | input | N_GEN | General engine event pulses |
| tx_evt | input | N_TX | Transmit endpoint event pulses |
| rx_evt | input | N_RX | Receive endpoint event pulses |
| sof_evt | input | 1 | Start-of-frame packet seen |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, always driven |
| irq_eng | output | 1 | Engine interrupt request |
| irq_sof | output | 1 | Start-of-frame interrupt request |
| role_device | output | 1 | Role select, 1 = device, 0 = host |
| core_rst_n | output | 1 | Core reset, active low |
| phy_en | output | 1 | PHY enable |

## Verification
Each pending machine's state appears directly at bit 14 or bit 13 of `reg_rdata`. A machine that takes a wrong transition therefore shows the wrong bit in the very next cycle. It also shows on the matching interrupt line in that same cycle whenever the enable is set. The bench sweeps every combination of the two starting flag states, both enables, both event kinds, a read and a clearing write. It computes each next state from the rules above. This catches a swapped clear mechanism, a lost event on a same-cycle clear, or an interrupt line that ignores its enable, within one cycle of the stimulus.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
    localparam int REG_W         = 32;
    localparam int BIT_ENG_PEND  = 14;
    localparam int BIT_SOF_PEND  = 13;
    localparam int BIT_SOF_CLR   = 12;
    localparam int BIT_ENG_EN    = 11;
    localparam int BIT_SOF_EN    = 10;
    localparam int BIT_ROLE      = 4;
    localparam int BIT_CORE_RSTN = 2;
    localparam int BIT_PHY_EN    = 0;

    // storage bits: 18 and 11..0 (bit 12 is a command, not storage)
    localparam logic [REG_W-1:0] RW_MASK = 32'h0004_0FFF;
    localparam logic [REG_W-1:0] RST_VAL = 32'h0000_0810;

    typedef enum logic {
        PEND_IDLE   = 1'b0,
        PEND_ACTIVE = 1'b1
    } pend_state_e;
endpackage

// File: rtl/usbirq_evt_merge.sv
module usbirq_evt_merge #(
    parameter int N_GEN = 8,
    parameter int N_TX  = 4,
    parameter int N_RX  = 4
) (
    input  logic [N_GEN-1:0] gen_evt,
    input  logic [N_TX-1:0]  tx_evt,
    input  logic [N_RX-1:0]  rx_evt,
    output logic             eng_hit
);
    localparam int N_ALL = N_GEN + N_TX + N_RX;

    logic [N_ALL-1:0] all_evt;

    assign all_evt = {rx_evt, tx_evt, gen_evt};

    // OR of every engine event source
    always_comb begin
        eng_hit = 1'b0;
        for (int i = 0; i < N_ALL; i++) begin
            eng_hit = eng_hit | all_evt[i];
        end
    end
endmodule

// File: rtl/usbirq_pend_fsm.sv
module usbirq_pend_fsm
    import usbirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic pend_o,
    output logic irq_o
);
    pend_state_e state_q, state_d;

    // next-state logic; a set always beats a clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_IDLE: begin
                if (set_i) state_d = PEND_ACTIVE;
            end
            PEND_ACTIVE: begin
                if (clr_i && !set_i) state_d = PEND_IDLE;
            end
            default: state_d = PEND_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PEND_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        pend_o = (state_q == PEND_ACTIVE);
        irq_o  = pend_o && en_i;
    end
endmodule

// File: rtl/usbirq_ctl_reg.sv
module usbirq_ctl_reg
    import usbirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             eng_pend,
    input  logic             sof_pend,
    output logic [REG_W-1:0] ctl_q,
    output logic             sof_clr_cmd,
    output logic [REG_W-1:0] rdata
);
    // storage bits only; everything else stays at its reset value (0)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ctl_q <= RST_VAL;
        else if (wr_en) ctl_q <= (ctl_q & ~RW_MASK) | (wdata & RW_MASK);
    end

    assign sof_clr_cmd = wr_en && wdata[BIT_SOF_CLR];

    always_comb begin
        rdata               = ctl_q & RW_MASK;
        rdata[BIT_ENG_PEND] = eng_pend;
        rdata[BIT_SOF_PEND] = sof_pend;
    end
endmodule

// File: rtl/usbirq_ctl.sv
module usbirq_ctl
    import usbirq_pkg::*;
#(
    parameter int N_GEN = 8,
    parameter int N_TX  = 4,
    parameter int N_RX  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_GEN-1:0] gen_evt,
    input  logic [N_TX-1:0]  tx_evt,
    input  logic [N_RX-1:0]  rx_evt,
    input  logic             sof_evt,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq_eng,
    output logic             irq_sof,
    output logic             role_device,
    output logic             core_rst_n,
    output logic             phy_en
);
    logic             eng_hit;
    logic             eng_pend;
    logic             sof_pend;
    logic             sof_clr_cmd;
    logic [REG_W-1:0] ctl_q;

    usbirq_evt_merge #(.N_GEN(N_GEN), .N_TX(N_TX), .N_RX(N_RX)) u_merge (
        .gen_evt (gen_evt),
        .tx_evt  (tx_evt),
        .rx_evt  (rx_evt),
        .eng_hit (eng_hit)
    );

    usbirq_ctl_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .wdata       (reg_wdata),
        .eng_pend    (eng_pend),
        .sof_pend    (sof_pend),
        .ctl_q       (ctl_q),
        .sof_clr_cmd (sof_clr_cmd),
        .rdata       (reg_rdata)
    );

    // engine flag: cleared by a read
    usbirq_pend_fsm u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (eng_hit),
        .clr_i  (reg_rd),
        .en_i   (ctl_q[BIT_ENG_EN]),
        .pend_o (eng_pend),
        .irq_o  (irq_eng)
    );

    // frame flag: cleared by the write-one command bit
    usbirq_pend_fsm u_sof (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sof_evt),
        .clr_i  (sof_clr_cmd),
        .en_i   (ctl_q[BIT_SOF_EN]),
        .pend_o (sof_pend),
        .irq_o  (irq_sof)
    );

    assign role_device = ctl_q[BIT_ROLE];
    assign core_rst_n  = ctl_q[BIT_CORE_RSTN];
    assign phy_en      = ctl_q[BIT_PHY_EN];
endmodule

// File: rtl/usbirq_ctl_chk.sv
module usbirq_ctl_chk #(
    parameter int N_GEN = 8,
    parameter int N_TX  = 4,
    parameter int N_RX  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_GEN-1:0] gen_evt,
    input logic [N_TX-1:0]  tx_evt,
    input logic [N_RX-1:0]  rx_evt,
    input logic             sof_evt,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             irq_eng,
    input logic             irq_sof,
    input logic             role_device,
    input logic             core_rst_n,
    input logic             phy_en
);
    logic any_eng;
    assign any_eng = (|gen_evt) || (|tx_evt) || (|rx_evt);

    AST_ENG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        any_eng |=> reg_rdata[14]); // R2
    AST_ENG_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !any_eng) |=> !reg_rdata[14]); // R3
    AST_ENG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[14] && !reg_rd) |=> reg_rdata[14]); // R6
    AST_SOF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sof_evt |=> reg_rdata[13]); // R4
    AST_SOF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[13] && !(reg_wr && reg_wdata[12])) |=> reg_rdata[13]); // R5
    AST_SOF_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[12] && !sof_evt) |=> !reg_rdata[13]); // R5
    AST_CLR_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[12]); // R5
    AST_IRQ_ENG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eng == (reg_rdata[14] && reg_rdata[11])); // R7
    AST_IRQ_SOF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sof == (reg_rdata[13] && reg_rdata[10])); // R7
    AST_CTL_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (role_device == reg_rdata[4]) && (core_rst_n == reg_rdata[2]) && (phy_en == reg_rdata[0])); // R9
endmodule

bind usbirq_ctl usbirq_ctl_chk #(.N_GEN(N_GEN), .N_TX(N_TX), .N_RX(N_RX)) u_chk (.*);

// File: tb/usbirq_ctl_bench.sv
`timescale 1ns/1ps
module usbirq_ctl_bench;
    localparam int N_GEN = 8;
    localparam int N_TX  = 4;
    localparam int N_RX  = 4;
    localparam logic [31:0] MASK_RW = 32'h0004_0FFF;
    localparam logic [31:0] VAL_RST = 32'h0000_0810;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_GEN-1:0] gen_evt = '0;
    logic [N_TX-1:0]  tx_evt = '0;
    logic [N_RX-1:0]  rx_evt = '0;
    logic             sof_evt = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_rd = 1'b0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             irq_eng, irq_sof, role_device, core_rst_n, phy_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usbirq_ctl #(.N_GEN(N_GEN), .N_TX(N_TX), .N_RX(N_RX)) u_usbirq_ctl (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // one bus/event cycle: drive after a falling edge, release after the next
    task automatic apply(input int src, input bit ev_e, input bit ev_s,
                         input bit wr, input logic [31:0] wd, input bit rd);
        @(negedge clk);
        if (ev_e) begin
            case (src % 3)
                0: gen_evt[src % N_GEN] = 1'b1;
                1: tx_evt[src % N_TX]   = 1'b1;
                default: rx_evt[src % N_RX] = 1'b1;
            endcase
        end
        sof_evt = ev_s; reg_wr = wr; reg_wdata = wd; reg_rd = rd;
        @(negedge clk);
        gen_evt = '0; tx_evt = '0; rx_evt = '0;
        sof_evt = 1'b0; reg_wr = 1'b0; reg_wdata = '0; reg_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rdata", reg_rdata, VAL_RST);
        chk("R1 irq", {30'd0, irq_eng, irq_sof}, 32'd0);
        chk("R1 pins", {29'd0, role_device, core_rst_n, phy_en}, 32'h4);

        // near-exhaustive sweep: enables x start state x stimulus
        for (int en = 0; en < 4; en++) begin
            for (int st = 0; st < 4; st++) begin
                for (int stim = 0; stim < 16; stim++) begin
                    logic [31:0] ctrl;
                    bit e0, s0, ev_e, ev_s, rd, clr, e1, s1;
                    int src;
                    src  = en * 64 + st * 16 + stim;
                    ctrl = VAL_RST;
                    ctrl[11] = en[1];
                    ctrl[10] = en[0];
                    e0 = st[1]; s0 = st[0];
                    ev_e = stim[3]; ev_s = stim[2]; rd = stim[1]; clr = stim[0];
                    apply(0, 1'b0, 1'b0, 1'b1, ctrl | 32'h1000, 1'b1);
                    apply(src, e0, s0, 1'b0, 32'd0, 1'b0);
                    chk("R2 setup eng", {31'd0, reg_rdata[14]}, {31'd0, e0});
                    chk("R4 setup sof", {31'd0, reg_rdata[13]}, {31'd0, s0});
                    apply(src + 1, ev_e, ev_s, clr, ctrl | (clr ? 32'h1000 : 32'h0), rd);
                    e1 = ev_e || (e0 && !rd);
                    s1 = ev_s || (s0 && !clr);
                    chk("R2/R3/R6/R8 eng pend", {31'd0, reg_rdata[14]}, {31'd0, e1});
                    chk("R4/R5/R8 sof pend", {31'd0, reg_rdata[13]}, {31'd0, s1});
                    chk("R7 irq_eng", {31'd0, irq_eng}, {31'd0, e1 && en[1]});
                    chk("R7 irq_sof", {31'd0, irq_sof}, {31'd0, s1 && en[0]});
                end
            end
        end

        // R3: the clearing read still returns the set flag
        apply(0, 1'b1, 1'b0, 1'b0, 32'd0, 1'b0);
        @(negedge clk);
        reg_rd = 1'b1;
        #1 chk("R3 read shows flag", {31'd0, reg_rdata[14]}, 32'd1);
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R3 cleared after read", {31'd0, reg_rdata[14]}, 32'd0);

        // R9/R6/R5: walking one over every bit, flags cleared first
        apply(0, 1'b0, 1'b0, 1'b1, 32'h1000, 1'b1);
        for (int i = 0; i < 32; i++) begin
            logic [31:0] w;
            w = 32'd1 << i;
            apply(0, 1'b0, 1'b0, 1'b1, w, 1'b0);
            chk("R9/R6/R5 readback", reg_rdata, w & MASK_RW);
            chk("R9 pins", {29'd0, role_device, core_rst_n, phy_en},
                {29'd0, w[4], w[2], w[0]});
            chk("R7 no irq without flag", {30'd0, irq_eng, irq_sof}, 32'd0);
        end

        // R7: flags latch while disabled, lines rise when enabled
        apply(0, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0);
        apply(5, 1'b1, 1'b1, 1'b0, 32'd0, 1'b0);
        chk("R7 latch disabled", {reg_rdata[14:13], irq_eng, irq_sof}, 4'b1100);
        apply(0, 1'b0, 1'b0, 1'b1, 32'h0C00, 1'b0);
        chk("R7 enable raises", {30'd0, irq_eng, irq_sof}, 32'd3);
        // R5: frame flag survives a read, R6: clear bit leaves engine flag
        apply(0, 1'b0, 1'b0, 1'b0, 32'd0, 1'b1);
        chk("R5 read keeps sof", {30'd0, reg_rdata[14:13]}, 32'd1);
        apply(1, 1'b1, 1'b0, 1'b0, 32'd0, 1'b0);
        apply(0, 1'b0, 1'b0, 1'b1, 32'h1C00, 1'b0);
        chk("R6 clear bit only sof", {30'd0, reg_rdata[14:13]}, 32'd2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule